// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block drives the timing side of a parallel LCD panel. It produces horizontal sync, vertical sync, a data-enable strobe, the pixel position inside the active window and a one-cycle frame-start pulse. All counters run on the pixel clock. Software programs the raster through a small word-wide write port. The programmable values are the active size, the line and frame totals, the distance from the leading edge of sync to the first active pixel or line, the sync widths, the sync polarities, a run bit and an output-float bit.

Timing values are held in a shadow set. The shadow set is copied into the working set only when a frame ends, so a change never splits a frame. While the block is halted, the copy is made on every cycle. The block also reports a start delay for downstream logic. This delay is the vertical blanking in lines, clamped to a ceiling of 30. After reset the block is halted and the pad drivers are released. Nothing reaches the panel until software clears the float bit.

Top module: `lcd_raster_gen`

## Requirements
- R1: While reset is asserted and right after it, run is 0, data-enable, frame-start, the positions and pad_drive_en are 0, and both syncs sit at logic 0.
- R2: When running, each line lasts htotal clocks (htotal = address 2 bits [15:0]). lcd_hsync is active for the first hsync-width clocks of each line (hsync-width = address 4 bits [15:0]).
- R3: When running, each frame lasts vtotal lines (vtotal = address 3 bits [15:0]). lcd_vsync is active for the first vsync-width lines of the frame (vsync-width = address 4 bits [31:16]).
- R4: lcd_de is high only when the clock within the line lies in [hoffset, hoffset+width) and the line lies in [voffset, voffset+height). hoffset = address 2 bits [31:16] and voffset = address 3 bits [31:16], each counted from the leading edge of sync. width = address 1 bits [15:0] and height = address 1 bits [31:16].
- R5: pix_x and pix_y are 0 at the first active pixel and count up across the window. Both read 0 whenever lcd_de is low.
- R6: Control register (address 0) bit 1 set drives lcd_hsync active-low. Bit 2 set drives lcd_vsync active-low. When a bit is clear, that sync is active-high.
- R7: pad_drive_en is the inverse of control bit 3. Bit 3 resets to 1, so the pads float until software clears it.
- R8: Control bit 0 is the run bit. While it is 0 the counters hold at zero, both syncs are inactive and lcd_de is low. The first cycle after the bit is set shows frame_start.
- R9: Writes to addresses 1 to 4 reach the working timing only at the boundary after the last clock of the running frame. While halted, they reach it on the next cycle.
- R10: frame_start is high for exactly the cycle in which both counters are zero while running.
- R11: data_start_dly equals vtotal minus height, clamped to 30, and is 0 when vtotal is not greater than height. It is computed from the working timing.
- R12: A write to addresses 5 to 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| lcd_hsync | output | 1 | Horizontal sync after polarity |
| lcd_vsync | output | 1 | Vertical sync after polarity |
| lcd_de | output | 1 | Active-window data enable |
| pix_x | output | 16 | Column inside the active window |
| pix_y | output | 16 | Row inside the active window |
| frame_start | output | 1 | One-cycle pulse at counter origin |
| pad_drive_en | output | 1 | Pad output enable, 0 = floating |
| data_start_dly | output | 5 | Clamped vertical blanking in lines |

## Verification
A write presented before a clock edge changes the control bits at that edge. Polarity, float and run therefore show on the outputs in the following cycle. A write to a timing field stays invisible until the register stage after the final clock of the frame, or one cycle after the write while halted. Every output is a decode of the counter and configuration registers with no extra stage, so each result is due in the cycle right after the edge that moved the counters. The bench model advances its own state at each rising edge, using the pre-edge values, and compares all outputs at the falling edge of the same cycle. Every one-edge latency and every frame-boundary latency is therefore checked at the cycle it is due.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;

  localparam int WORD_W  = 32;
  localparam int FIELD_W = WORD_W / 2;
  localparam int ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL   = 3'd0,
    ADR_ACTIVE = 3'd1,
    ADR_HTIME  = 3'd2,
    ADR_VTIME  = 3'd3,
    ADR_SYNCW  = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic [FIELD_W-1:0] act_w;
    logic [FIELD_W-1:0] act_h;
    logic [FIELD_W-1:0] h_tot;
    logic [FIELD_W-1:0] h_off;
    logic [FIELD_W-1:0] v_tot;
    logic [FIELD_W-1:0] v_off;
    logic [FIELD_W-1:0] hs_w;
    logic [FIELD_W-1:0] vs_w;
  } timing_t;

  // pos lies inside [start, start+len)
  function automatic logic in_window(input logic [FIELD_W-1:0] pos,
                                     input logic [FIELD_W-1:0] start,
                                     input logic [FIELD_W-1:0] len);
    logic [FIELD_W:0] stop;
    stop = {1'b0, start} + {1'b0, len};
    return (pos >= start) && ({1'b0, pos} < stop);
  endfunction

  // counter reaches its final value for a given period
  function automatic logic at_last(input logic [FIELD_W-1:0] cnt,
                                   input logic [FIELD_W-1:0] period);
    return ({1'b0, cnt} + 1'b1) >= {1'b0, period};
  endfunction

  // vertical blanking in lines, clamped to cap
  function automatic logic [FIELD_W-1:0] sat_start_delay(input logic [FIELD_W-1:0] v_tot,
                                                         input logic [FIELD_W-1:0] act_h,
                                                         input logic [FIELD_W-1:0] cap);
    logic [FIELD_W-1:0] gap;
    if (v_tot <= act_h) return '0;
    gap = v_tot - act_h;
    return (gap > cap) ? cap : gap;
  endfunction

endpackage

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
  import lcd_raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              load,
  output timing_t           act_cfg,
  output logic              run,
  output logic              hs_inv,
  output logic              vs_inv,
  output logic              floating
);

  timing_t shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow   <= '0;
      run      <= 1'b0;
      hs_inv   <= 1'b0;
      vs_inv   <= 1'b0;
      floating <= 1'b1;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: begin
          run      <= wr_data[0];
          hs_inv   <= wr_data[1];
          vs_inv   <= wr_data[2];
          floating <= wr_data[3];
        end
        ADR_ACTIVE: begin
          shadow.act_w <= wr_data[FIELD_W-1:0];
          shadow.act_h <= wr_data[WORD_W-1:FIELD_W];
        end
        ADR_HTIME: begin
          shadow.h_tot <= wr_data[FIELD_W-1:0];
          shadow.h_off <= wr_data[WORD_W-1:FIELD_W];
        end
        ADR_VTIME: begin
          shadow.v_tot <= wr_data[FIELD_W-1:0];
          shadow.v_off <= wr_data[WORD_W-1:FIELD_W];
        end
        ADR_SYNCW: begin
          shadow.hs_w <= wr_data[FIELD_W-1:0];
          shadow.vs_w <= wr_data[WORD_W-1:FIELD_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_cfg <= '0;
    else if (load) act_cfg <= shadow;
  end

  assert_load_copies_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (act_cfg == $past(shadow)));

  assert_reset_floats_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> floating);

endmodule

// File: rtl/lcd_axis_counter.sv
module lcd_axis_counter
  import lcd_raster_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               step,
  input  logic [FIELD_W-1:0] period,
  output logic [FIELD_W-1:0] cnt,
  output logic               last
);

  assign last = at_last(cnt, period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (step)     cnt <= last ? '0 : cnt + 1'b1;
  end

  assert_halt_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != '0) |-> (cnt < period));

endmodule

// File: rtl/lcd_sync_decode.sv
module lcd_sync_decode
  import lcd_raster_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               hs_inv,
  input  logic               vs_inv,
  input  timing_t            cfg,
  input  logic [FIELD_W-1:0] hcnt,
  input  logic [FIELD_W-1:0] vcnt,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic [FIELD_W-1:0] x,
  output logic [FIELD_W-1:0] y,
  output logic               origin
);

  logic hs_act, vs_act, h_in, v_in;

  assign hs_act = run && (hcnt < cfg.hs_w);
  assign vs_act = run && (vcnt < cfg.vs_w);
  assign h_in   = in_window(hcnt, cfg.h_off, cfg.act_w);
  assign v_in   = in_window(vcnt, cfg.v_off, cfg.act_h);

  assign hsync  = hs_act ^ hs_inv;
  assign vsync  = vs_act ^ vs_inv;
  assign de     = run && h_in && v_in;
  assign x      = de ? (hcnt - cfg.h_off) : '0;
  assign y      = de ? (vcnt - cfg.v_off) : '0;
  assign origin = run && (hcnt == '0) && (vcnt == '0);

  assert_pos_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> ((x < cfg.act_w) && (y < cfg.act_h)));

  assert_origin_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (origin && run && cfg.h_tot > 16'd1) |=> !origin);

endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
  import lcd_raster_pkg::*;
#(
  parameter int DLY_CAP = 30,
  parameter int DLY_W   = $clog2(DLY_CAP + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  output logic               lcd_hsync,
  output logic               lcd_vsync,
  output logic               lcd_de,
  output logic [FIELD_W-1:0] pix_x,
  output logic [FIELD_W-1:0] pix_y,
  output logic               frame_start,
  output logic               pad_drive_en,
  output logic [DLY_W-1:0]   data_start_dly
);

  localparam logic [FIELD_W-1:0] CAP_F = FIELD_W'(DLY_CAP);

  timing_t            cfg;
  logic               run, hs_inv, vs_inv, floating;
  logic [FIELD_W-1:0] hcnt, vcnt;
  logic               h_last, v_last;
  logic               frame_end, load;

  assign frame_end = run && h_last && v_last;
  assign load      = !run || frame_end;

  lcd_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(load), .act_cfg(cfg), .run(run),
    .hs_inv(hs_inv), .vs_inv(vs_inv), .floating(floating)
  );

  lcd_axis_counter u_hcnt (
    .clk(clk), .rst_n(rst_n), .run(run), .step(1'b1),
    .period(cfg.h_tot), .cnt(hcnt), .last(h_last)
  );

  lcd_axis_counter u_vcnt (
    .clk(clk), .rst_n(rst_n), .run(run), .step(h_last),
    .period(cfg.v_tot), .cnt(vcnt), .last(v_last)
  );

  lcd_sync_decode u_dec (
    .clk(clk), .rst_n(rst_n), .run(run), .hs_inv(hs_inv), .vs_inv(vs_inv),
    .cfg(cfg), .hcnt(hcnt), .vcnt(vcnt), .hsync(lcd_hsync),
    .vsync(lcd_vsync), .de(lcd_de), .x(pix_x), .y(pix_y),
    .origin(frame_start)
  );

  assign pad_drive_en   = !floating;
  assign data_start_dly = DLY_W'(sat_start_delay(cfg.v_tot, cfg.act_h, CAP_F));

  assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> frame_start);

  assert_dly_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    data_start_dly <= DLY_W'(DLY_CAP));

  assert_frame_end_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && run) |=> (frame_start || !run));

endmodule

// File: tb/lcd_raster_gen_tb_top.sv
module lcd_raster_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        lcd_hsync, lcd_vsync, lcd_de, frame_start, pad_drive_en;
  logic [15:0] pix_x, pix_y;
  logic [4:0]  data_start_dly;

  always #10 clk = ~clk;

  lcd_raster_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
    .lcd_de(lcd_de), .pix_x(pix_x), .pix_y(pix_y),
    .frame_start(frame_start), .pad_drive_en(pad_drive_en),
    .data_start_dly(data_start_dly)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // model state: ctrl, shadow fields, working fields, counters
  int m_run, m_hinv, m_vinv, m_float;
  int s_w, s_h, s_ht, s_ho, s_vt, s_vo, s_hs, s_vs;
  int a_w, a_h, a_ht, a_ho, a_vt, a_vo, a_hs, a_vs;
  int hc, vc;

  task automatic model_reset();
    m_run = 0; m_hinv = 0; m_vinv = 0; m_float = 1;
    s_w = 0; s_h = 0; s_ht = 0; s_ho = 0; s_vt = 0; s_vo = 0; s_hs = 0; s_vs = 0;
    a_w = 0; a_h = 0; a_ht = 0; a_ho = 0; a_vt = 0; a_vo = 0; a_hs = 0; a_vs = 0;
    hc = 0; vc = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit hl, vl, ld;
      hl = (hc + 1 >= a_ht);
      vl = (vc + 1 >= a_vt);
      ld = (m_run == 0) || (hl && vl);
      if (m_run == 0) begin hc = 0; vc = 0; end
      else if (hl) begin hc = 0; vc = vl ? 0 : vc + 1; end
      else hc = hc + 1;
      if (ld) begin
        a_w = s_w; a_h = s_h; a_ht = s_ht; a_ho = s_ho;
        a_vt = s_vt; a_vo = s_vo; a_hs = s_hs; a_vs = s_vs;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_run = wr_data[0]; m_hinv = wr_data[1];
                      m_vinv = wr_data[2]; m_float = wr_data[3]; end
          3'd1: begin s_w = wr_data[15:0]; s_h = wr_data[31:16]; end
          3'd2: begin s_ht = wr_data[15:0]; s_ho = wr_data[31:16]; end
          3'd3: begin s_vt = wr_data[15:0]; s_vo = wr_data[31:16]; end
          3'd4: begin s_hs = wr_data[15:0]; s_vs = wr_data[31:16]; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_de, e_hs, e_vs, e_dly;
      e_de = (m_run != 0) && hc >= a_ho && hc < a_ho + a_w && vc >= a_vo && vc < a_vo + a_h;
      e_hs = ((m_run != 0) && hc < a_hs) ^ m_hinv;
      e_vs = ((m_run != 0) && vc < a_vs) ^ m_vinv;
      e_dly = (a_vt > a_h) ? ((a_vt - a_h > 30) ? 30 : a_vt - a_h) : 0;
      chk("R2/R6 hsync", lcd_hsync, e_hs);
      chk("R3/R6 vsync", lcd_vsync, e_vs);
      chk("R4/R8 de", lcd_de, e_de);
      chk("R5 pix_x", pix_x, e_de ? hc - a_ho : 0);
      chk("R5 pix_y", pix_y, e_de ? vc - a_vo : 0);
      chk("R10/R8 frame_start", frame_start, (m_run != 0) && hc == 0 && vc == 0);
      chk("R7 pad_drive_en", pad_drive_en, !m_float);
      chk("R11/R9 data_start_dly", data_start_dly, e_dly);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    idle(3);
    // R1: reset state
    chk("R1 de", lcd_de, 0);
    chk("R1 frame_start", frame_start, 0);
    chk("R1 hsync", lcd_hsync, 0);
    chk("R1 vsync", lcd_vsync, 0);
    chk("R1 pix_x", pix_x, 0);
    chk("R7 pad_drive_en reset", pad_drive_en, 0);
    rst_n = 1'b1;
    idle(2);
    // timing: width 4 height 3, htotal 10 hoff 3, vtotal 8 voff 3, hs 2 vs 1
    wr(1, {16'd3, 16'd4});
    wr(2, {16'd3, 16'd10});
    wr(3, {16'd3, 16'd8});
    wr(4, {16'd1, 16'd2});
    wr(0, 32'h1);                 // R8 run, R7 drive
    idle(200);
    wr(7, 32'hFFFF_FFFF);         // R12 ignored
    wr(5, 32'h0000_0000);         // R12 ignored
    idle(100);
    wr(2, {16'd4, 16'd12});       // R9 change mid-frame
    wr(1, {16'd3, 16'd5});
    idle(300);
    wr(0, 32'h7);                 // R6 both active-low
    idle(200);
    wr(0, 32'h3);                 // R6 hsync only
    wr(3, {16'd3, 16'd50});       // R11 saturates at 30
    idle(1300);
    wr(0, 32'hB);                 // R7 float while running
    idle(50);
    wr(0, 32'h0);                 // R8 halt
    idle(30);
    wr(2, {16'd3, 16'd9});        // R9 halted: immediate
    wr(3, {16'd2, 16'd2});        // R11 vtotal below height -> 0
    idle(5);
    wr(0, 32'h1);
    idle(100);
    wr(3, {16'd2, 16'd7});        // R11 gap 4
    idle(300);
    finish_run();
  end

endmodule